// File: doc/BRIEF.md
# Elevator Car Unit Controller with Emergency Return

This block is the control core for a single elevator car. It compares a requested floor number against the car's present floor. It then commands the car to travel up or down, or to hold its door open. Once the car stops at the target, the door stays open for a minimum number of one-second ticks before the controller returns to waiting. The number of ticks is set by a parameter.

A fire alarm input takes priority over all normal activity. When the alarm is raised, the controller abandons whatever it was doing and drives the car down to floor 1, the lobby. There it opens the door. Normal service comes back only after this emergency sequence has finished. It always restarts from the waiting state.

Every output is a registered decode of the present state, and all state changes happen on the rising clock edge. The request comes from an external resolver. Floor sensing and motor drive also live outside this block.

Top module: `elev_unit_ctrl`

## Requirements
- R1: While the synchronous reset is high, and in the cycle after it, the outputs are go_up=0, go_down=0, door_open=1, tmr_start=0. This is the waiting state.
- R2: In the waiting state, with no alarm, a request above the floor starts upward travel on the next edge. A request below the floor starts downward travel. An equal request keeps the controller waiting.
- R3: The outputs are fixed per state, written as (go_up, go_down, door_open, tmr_start). Waiting is 0,0,1,0. Upward travel is 1,0,0,0. Downward travel is 0,1,0,0. Hold-open is 0,0,1,1. Emergency descent is 0,1,0,0. Emergency door is 0,0,1,0. tmr_start is never 1 without door_open.
- R4: Upward travel continues while the request is above the floor and otherwise moves to hold-open. Downward travel continues while the request is below the floor and otherwise moves to hold-open.
- R5: Hold-open counts sec_tick pulses starting from zero on each entry. It returns to waiting on the edge after HOLD_TICKS pulses have been counted. Without ticks it stays indefinitely.
- R6: door_open is never 1 in a cycle where go_up or go_down is 1, and go_up and go_down are never both 1.
- R7: If fire is high at an edge while in any normal state, the next state is emergency descent. No cycle that follows a cycle with fire high shows go_up.
- R8: Emergency descent continues while the floor is above 1. Otherwise it moves to the emergency door state, which holds while fire stays high.
- R9: Dropping fire during emergency descent does not end the descent. From the emergency door state, with fire low, the next state is waiting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_floor | input | FLOOR_W | Requested floor number, unsigned |
| cur_floor | input | FLOOR_W | Present car floor number, unsigned, lobby is 1 |
| fire | input | 1 | Fire alarm, active high |
| sec_tick | input | 1 | One-cycle pulse per second for the door hold |
| go_up | output | 1 | Drive car upward |
| go_down | output | 1 | Drive car downward |
| door_open | output | 1 | Hold door open |
| tmr_start | output | 1 | Door hold timer running |

## Verification
Every output is a decode of the state register. An input pattern present before rising edge k therefore shows on the outputs right after edge k, one cycle later, with no further latency. The door hold ends on the edge after the HOLD_TICKS-th counted tick. The bench drives inputs and compares outputs on the falling edge. A behavioural reference model advances on the same rising edge from the same sampled inputs, so every comparison falls half a cycle after the result became due. A small car model in the bench moves cur_floor by one floor per cycle of travel, right after each comparison. This makes the floor change only while the car is moving.

// File: rtl/elev_unit_ctrl.sv
module elev_unit_ctrl #(
  parameter int FLOOR_W    = 4,
  parameter int HOLD_TICKS = 10
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FLOOR_W-1:0] req_floor,
  input  logic [FLOOR_W-1:0] cur_floor,
  input  logic               fire,
  input  logic               sec_tick,
  output logic               go_up,
  output logic               go_down,
  output logic               door_open,
  output logic               tmr_start
);
  localparam int TW = $clog2(HOLD_TICKS + 1);
  localparam logic [TW-1:0] HOLD_V = TW'(HOLD_TICKS);
  localparam logic [FLOOR_W-1:0] LOBBY = FLOOR_W'(1);

  typedef enum logic [2:0] {
    S_WAIT, S_UP, S_DN, S_HOLD, S_FDN, S_FDOOR
  } st_t;

  st_t st, st_nx;
  logic [TW-1:0] hold_cnt;

  wire above = req_floor > cur_floor;
  wire below = req_floor < cur_floor;
  wire hold_done = hold_cnt == HOLD_V;
  wire in_normal = (st == S_WAIT) || (st == S_UP) || (st == S_DN) || (st == S_HOLD);

  always_comb begin
    st_nx = st;
    if (in_normal && fire) begin
      st_nx = S_FDN;
    end else begin
      case (st)
        S_WAIT:  st_nx = above ? S_UP : (below ? S_DN : S_WAIT);
        S_UP:    st_nx = above ? S_UP : S_HOLD;
        S_DN:    st_nx = below ? S_DN : S_HOLD;
        S_HOLD:  st_nx = hold_done ? S_WAIT : S_HOLD;
        S_FDN:   st_nx = (cur_floor > LOBBY) ? S_FDN : S_FDOOR;
        S_FDOOR: st_nx = fire ? S_FDOOR : S_WAIT;
        default: st_nx = S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st <= S_WAIT;
    else     st <= st_nx;
  end

  always_ff @(posedge clk) begin
    if (rst || st != S_HOLD) hold_cnt <= '0;
    else if (sec_tick && !hold_done) hold_cnt <= hold_cnt + 1'b1;
  end

  assign go_up     = st == S_UP;
  assign go_down   = (st == S_DN) || (st == S_FDN);
  assign door_open = (st == S_WAIT) || (st == S_HOLD) || (st == S_FDOOR);
  assign tmr_start = st == S_HOLD;
endmodule

// File: rtl/elev_unit_ctrl_chk.sv
module elev_unit_ctrl_chk #(
  parameter int HOLD_TICKS = 10
) (
  input logic clk,
  input logic rst,
  input logic fire,
  input logic sec_tick,
  input logic go_up,
  input logic go_down,
  input logic door_open,
  input logic tmr_start
);
  int ck_cnt;

  always_ff @(posedge clk) begin
    if (rst || !tmr_start) ck_cnt <= 0;
    else if (sec_tick && ck_cnt < HOLD_TICKS) ck_cnt <= ck_cnt + 1;
  end

  AST_DOOR_STILL: assert property (@(posedge clk) disable iff (rst) door_open |-> !(go_up || go_down)); // R6
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst) !(go_up && go_down)); // R6
  AST_TMR_DOOR: assert property (@(posedge clk) disable iff (rst) tmr_start |-> door_open); // R3
  AST_FIRE_NO_UP: assert property (@(posedge clk) disable iff (rst) fire |=> !go_up); // R7
  AST_FIRE_HOLD_EXIT: assert property (@(posedge clk) disable iff (rst) (fire && tmr_start) |=> (go_down && !door_open)); // R7
  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (rst) ($fell(tmr_start) && door_open) |-> ck_cnt >= HOLD_TICKS); // R5
endmodule

bind elev_unit_ctrl elev_unit_ctrl_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
  .clk(clk), .rst(rst), .fire(fire), .sec_tick(sec_tick),
  .go_up(go_up), .go_down(go_down), .door_open(door_open), .tmr_start(tmr_start)
);

// File: tb/sim_elev_unit_ctrl.sv
module sim_elev_unit_ctrl;
  localparam int FW = 4;
  localparam int HOLD = 10;

  logic clk = 0, rst = 1, fire = 0, sec_tick = 0;
  logic [FW-1:0] req_floor = 4'd1, cur_floor = 4'd1;
  logic go_up, go_down, door_open, tmr_start;

  always #5 clk = ~clk;

  elev_unit_ctrl #(.FLOOR_W(FW), .HOLD_TICKS(HOLD)) u0 (
    .clk(clk), .rst(rst), .req_floor(req_floor), .cur_floor(cur_floor),
    .fire(fire), .sec_tick(sec_tick), .go_up(go_up), .go_down(go_down),
    .door_open(door_open), .tmr_start(tmr_start)
  );

  int total = 0, bad = 0, cycles = 0;
  string tag = "R1";
  bit car_on = 1;
  bit tick_every = 0;

  // reference model: 0 wait,1 up,2 down,3 hold,4 fire descent,5 fire door
  int m_st = 0, m_cnt = 0;
  always @(posedge clk) begin
    int q, f, nx;
    q = int'(req_floor); f = int'(cur_floor);
    if (rst) begin nx = 0; m_cnt = 0; end
    else begin
      nx = m_st;
      if (m_st < 4 && fire) nx = 4;
      else if (m_st == 0) nx = (q > f) ? 1 : (q < f) ? 2 : 0;
      else if (m_st == 1) nx = (q > f) ? 1 : 3;
      else if (m_st == 2) nx = (q < f) ? 2 : 3;
      else if (m_st == 3) nx = (m_cnt >= HOLD) ? 0 : 3;
      else if (m_st == 4) nx = (f > 1) ? 4 : 5;
      else nx = fire ? 5 : 0;
      if (m_st == 3 && nx == 3) begin
        if (sec_tick && m_cnt < HOLD) m_cnt++;
      end else m_cnt = 0;
    end
    m_st = nx;
  end

  function automatic logic [3:0] exp_out(int s);
    case (s)
      0: return 4'b0010;
      1: return 4'b1000;
      2: return 4'b0100;
      3: return 4'b0011;
      4: return 4'b0100;
      default: return 4'b0010;
    endcase
  endfunction

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cycles++;
      total++;
      if ({go_up, go_down, door_open, tmr_start} !== exp_out(m_st)) begin
        bad++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b", tag, cycles,
                 {go_up, go_down, door_open, tmr_start}, exp_out(m_st));
      end
      if (car_on && go_up) cur_floor = cur_floor + 1'b1;
      if (car_on && go_down) cur_floor = cur_floor - 1'b1;
      sec_tick = tick_every ? 1'b1 : ~sec_tick;
    end
  endtask

  task automatic expect_state(string t, logic [3:0] e);
    total++;
    if ({go_up, go_down, door_open, tmr_start} !== e) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", t, {go_up, go_down, door_open, tmr_start}, e);
    end
  endtask

  initial begin
    #300000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tag = "R1"; cyc(3);
    rst = 0; cyc(1);
    expect_state("R1 after reset", 4'b0010);
    tag = "R2 equal"; cyc(4);
    expect_state("R2 stays waiting", 4'b0010);
    tag = "R2 R4 up"; req_floor = 4'd5; cyc(1);
    expect_state("R2 starts up", 4'b1000);
    cyc(4);
    tag = "R4 R5 hold"; cyc(1);
    expect_state("R4 reaches hold", 4'b0011);
    cyc(2 * HOLD + 3);
    expect_state("R5 back to waiting", 4'b0010);
    tag = "R2 R4 down"; req_floor = 4'd2; cyc(1);
    expect_state("R2 starts down", 4'b0100);
    tick_every = 1;
    cyc(3 + HOLD + 3);
    expect_state("R5 fast ticks", 4'b0010);
    tag = "R5 no tick"; req_floor = 4'd3; tick_every = 0;
    cyc(3);
    sec_tick = 0; car_on = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); cycles++;
      sec_tick = 0;
    end
    total++;
    if (m_st != 3) begin bad++; $display("FAIL R5 setup model=%0d expected=3", m_st); end
    expect_state("R5 held without ticks", 4'b0011);
    car_on = 1;
    tag = "R7 fire in hold"; fire = 1; cyc(1);
    expect_state("R7 fire preempts hold", 4'b0100);
    tag = "R8 descent"; cyc(3);
    expect_state("R8 emergency door", 4'b0010);
    cyc(5);
    expect_state("R8 door held while fire", 4'b0010);
    tag = "R9 release"; fire = 0; cyc(1);
    expect_state("R9 back to waiting", 4'b0010);
    tag = "R7 fire going up"; req_floor = 4'd7; cyc(4);
    expect_state("R7 setup moving up", 4'b1000);
    fire = 1; cyc(1);
    expect_state("R7 up preempted", 4'b0100);
    tag = "R9 early release"; fire = 0; req_floor = 4'd9; cyc(1);
    expect_state("R9 descent continues", 4'b0100);
    cyc(8);
    tag = "R6 R3 mixed"; req_floor = 4'd4; tick_every = 1; cyc(40);
    req_floor = 4'd1; cyc(10);
    fire = 1; cyc(2); fire = 0; cyc(20);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule